// File: doc/BRIEF.md
# SPI Mode 3 Shift Master with Read Handshake

This block is a byte-wide serial master that runs entirely on the system clock. A write on its data port loads a byte and starts an eight-bit transfer. The block drives a serial clock that rests high and MOSI, most significant bit first. A flag reports when the byte has gone out.

The bit rate is chosen per transfer. In fast mode each serial clock half-period is one system clock. In timer mode each half-period lasts an 8-bit reload value plus one system clocks.

A companion parallel input port captures a byte that an external receive shifter has assembled. Every read of that port produces a one-cycle active-low strobe. The strobe can pace the external shifter or reset a downstream clock-mode converter. Software can write the next byte as soon as `done` is seen, so bytes can run back to back.

Top module: `spi3_shifter`

## Requirements
- R1: Out of reset `sclk` is 1, `mosi` is 0, `busy`, `done` and `overrun` are 0, and `ack_n` is 1.
- R2: A write (`wr_en` high) while `busy` is 0 is accepted at that clock edge. From the next cycle `busy` is 1, `done` is 0, `overrun` is 0 and `sclk` is 0.
- R3: Bits leave on `mosi` most significant first. Bit k of the transfer (k = 0..7) carries `wr_data[7-k]`.
- R4: `sclk` is 1 whenever no transfer is running. Within a transfer each bit drives it low for one half-period and then high for one half-period, giving eight rising edges per byte.
- R5: The half-period H is 1 system clock when `use_timer` is 0, and `reload`+1 system clocks when `use_timer` is 1. Both inputs are sampled at the accepting edge; later changes have no effect on the running transfer.
- R6: `mosi` changes only in the cycle in which `sclk` falls. It is stable across every rising edge and for the whole high half-period.
- R7: Exactly 16·H cycles after the accepting edge, `busy` falls and `done` rises. `done` then stays 1 until the next accepted write.
- R8: A write while `busy` is 1 is ignored, so the transfer continues with its original data and timing. It sets `overrun` from the next cycle, and `overrun` stays 1 until the next accepted write.
- R9: A read (`rd_en` high) captures `par_in` into `par_out` at that edge. It also drives `ack_n` low for the following cycle only. `par_out` holds between reads.
- R10: A write presented in the first cycle after `done` rises is accepted, so transfers can run back to back without idle cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Data write strobe, starts a transfer |
| wr_data | input | 8 | Byte to send |
| use_timer | input | 1 | 0: fast rate, 1: timer rate |
| reload | input | 8 | Timer reload; half-period is reload+1 clocks |
| rd_en | input | 1 | Parallel port read strobe |
| par_in | input | 8 | Byte from the external receive shifter |
| par_out | output | 8 | Captured parallel byte |
| sclk | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Serial data out |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Shift-done flag |
| overrun | output | 1 | Sticky write-while-busy flag |
| ack_n | output | 1 | One-cycle active-low read strobe |

## Verification
The first bit is on `mosi` with `sclk` low one cycle after the accepting edge. Bit k falls at 2k·H cycles and rises at (2k+1)·H cycles, and `done` appears at 16·H cycles. The bench counts cycles from the accepting edge and samples on the falling clock edge. At each of those cycles it compares `sclk` and `mosi` with values worked out from H and the byte. `par_out` and the low `ack_n` are due one cycle after a read, and `ack_n` returns high one cycle later. `overrun` is due one cycle after the rejected write. The bench checks each of these results in exactly that cycle.

// File: rtl/spi3_shifter.sv
module spi3_shifter #(
  parameter int DW = 8,
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          use_timer,
  input  logic [RW-1:0] reload,
  input  logic          rd_en,
  input  logic [DW-1:0] par_in,
  output logic [DW-1:0] par_out,
  output logic          sclk,
  output logic          mosi,
  output logic          busy,
  output logic          done,
  output logic          overrun,
  output logic          ack_n
);
  localparam int CW = (DW > 1) ? $clog2(DW) : 1;

  logic [DW-1:0] sh;
  logic [RW-1:0] lim, cnt;
  logic [CW-1:0] bits;

  wire accept = wr_en && !busy;
  wire tick   = busy && (cnt == '0);
  wire [RW-1:0] start_lim = use_timer ? reload : '0;

  assign mosi = sh[DW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '0;
      lim     <= '0;
      cnt     <= '0;
      bits    <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      overrun <= 1'b0;
      sclk    <= 1'b1;
    end else if (accept) begin
      sh      <= wr_data;
      lim     <= start_lim;
      cnt     <= start_lim;
      bits    <= '0;
      busy    <= 1'b1;
      done    <= 1'b0;
      overrun <= 1'b0;
      sclk    <= 1'b0;
    end else begin
      if (wr_en) overrun <= 1'b1;
      if (tick) begin
        cnt <= lim;
        if (!sclk) begin
          sclk <= 1'b1;
        end else if (bits == CW'(DW-1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          sclk <= 1'b0;
          sh   <= sh << 1;
          bits <= bits + 1'b1;
        end
      end else if (busy) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_out <= '0;
      ack_n   <= 1'b1;
    end else begin
      if (rd_en) par_out <= par_in;
      ack_n <= !rd_en;
    end
  end
endmodule

module spi3_shifter_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic rd_en,
  input logic sclk,
  input logic mosi,
  input logic busy,
  input logic done,
  input logic overrun,
  input logic ack_n
);
  // R4
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> sclk);
  // R6
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) sclk |-> $stable(mosi));
  // R2
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !busy) |=> (busy && !done && !sclk && !overrun));
  // R8
  overrun_chk: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && busy) |=> overrun);
  // R7
  done_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done);
  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !wr_en) |=> done);
  // R9
  ack_low_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_en |=> !ack_n);
  // R9
  ack_high_chk: assert property (@(posedge clk) disable iff (!rst_n) !rd_en |=> ack_n);
endmodule

bind spi3_shifter spi3_shifter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .sclk(sclk), .mosi(mosi),
  .busy(busy), .done(done), .overrun(overrun), .ack_n(ack_n)
);

// File: tb/sim_spi3_shifter.sv
module sim_spi3_shifter;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, use_timer = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = '0, reload = '0, par_in = '0, par_out;
  logic sclk, mosi, busy, done, overrun, ack_n;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  spi3_shifter u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .use_timer(use_timer),
    .reload(reload), .rd_en(rd_en), .par_in(par_in), .par_out(par_out), .sclk(sclk),
    .mosi(mosi), .busy(busy), .done(done), .overrun(overrun), .ack_n(ack_n)
  );

  // {use_timer, reload, data}
  localparam logic [16:0] VEC [6] = '{
    {1'b0, 8'h00, 8'hA5}, {1'b1, 8'h00, 8'h3C}, {1'b1, 8'h02, 8'h81},
    {1'b1, 8'h05, 8'h7E}, {1'b0, 8'h09, 8'hFF}, {1'b1, 8'h01, 8'h00}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive a write at a falling edge; return at the first falling edge after acceptance
  task automatic start(input logic ut, input logic [7:0] rl, input logic [7:0] d);
    use_timer = ut; reload = rl; wr_data = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; reload = ~rl; use_timer = ~ut; wr_data = ~d;
    chk(busy === 1'b1 && done === 1'b0 && sclk === 1'b0, "R2 start state",
        {busy, done, sclk}, 3'b100);
  endtask

  task automatic run_vec(input logic ut, input logic [7:0] rl, input logic [7:0] d);
    int h = ut ? int'(rl) + 1 : 1;
    int esc = 0, emo = 0;
    start(ut, rl, d);
    for (int n = 0; n < 16*h; n++) begin
      int k = n / (2*h);
      logic ph = ((n % (2*h)) >= h);
      if (sclk !== ph) esc++;
      if (mosi !== d[7-k]) emo++;
      @(negedge clk);
    end
    chk(esc == 0, "R4 R5 sclk pattern", esc, 0);
    chk(emo == 0, "R3 R6 mosi order", emo, 0);
    chk(done === 1'b1 && busy === 1'b0 && sclk === 1'b1, "R7 done at 16H",
        {done, busy, sclk}, 3'b101);
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(sclk === 1'b1 && mosi === 1'b0 && busy === 1'b0 && done === 1'b0 &&
        overrun === 1'b0 && ack_n === 1'b1, "R1 reset state",
        {sclk, mosi, busy, done, overrun, ack_n}, 6'b100001);

    // vector walk, back to back (R10)
    for (int i = 0; i < 6; i++) run_vec(VEC[i][16], VEC[i][15:8], VEC[i][7:0]);

    // R8: write during a transfer, H=4, data C3
    start(1'b1, 8'h03, 8'hC3);
    repeat (5) @(negedge clk);
    wr_en = 1'b1; wr_data = 8'h00;
    @(negedge clk);
    wr_en = 1'b0;
    chk(overrun === 1'b1 && busy === 1'b1, "R8 overrun set", {overrun, busy}, 2'b11);
    repeat (2) @(negedge clk);
    chk(mosi === 1'b1 && sclk === 1'b0, "R8 ignored write keeps data", {mosi, sclk}, 2'b10);
    repeat (56) @(negedge clk);
    chk(done === 1'b1 && overrun === 1'b1, "R8 R7 done with sticky overrun", {done, overrun}, 2'b11);
    repeat (10) @(negedge clk);
    chk(done === 1'b1, "R7 done holds", done, 1);
    run_vec(1'b0, 8'h00, 8'h55);
    chk(overrun === 1'b0, "R8 overrun cleared by accepted write", overrun, 0);

    // R9 parallel port read
    rd_en = 1'b1; par_in = 8'h5A;
    @(negedge clk);
    rd_en = 1'b0; par_in = 8'h0F;
    chk(par_out === 8'h5A && ack_n === 1'b0, "R9 capture and strobe", {par_out, ack_n}, {8'h5A, 1'b0});
    @(negedge clk);
    chk(ack_n === 1'b1 && par_out === 8'h5A, "R9 strobe one cycle", {par_out, ack_n}, {8'h5A, 1'b1});

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule